// File: doc/BRIEF.md
# Multi-FIFO Packet Write Steering Interface

This block sits between a link-layer processor and a set of transmit FIFOs. The processor writes packet data as 16-bit words. The block turns each accepted word into a one-cycle write strobe for exactly one FIFO, and passes along the word, a two-bit byte-valid marker and a start-of-packet marker. The FIFO storage is outside the block.

In addressed mode, the processor picks the destination FIFO in-band. It raises the shared strobe input together with the write enable, and the low byte of the bus then carries a FIFO index instead of data. Every later data word goes to that FIFO. In chunk mode, the same strobe input marks the first word of a packet. That word is forwarded as data with its start-of-packet marker set, and it goes to the most recently selected FIFO.

A modulo input travels with each word and says whether only the upper octet is valid. An address that is out of range, or a data word that arrives while no FIFO is selected, is dropped and sets a sticky error flag. The block does nothing while its enable input is low. All outputs are registered, so they appear one clock after the write.

Top module: `pktTxSteer`

## Requirements
- R1: After reset no FIFO is selected, `selErr` is 0 and all `fifoWr` bits are 0.
- R2: In addressed mode (`chunkMode`=0), a cycle with `pppEn`, `wrEn` and `xferStart` all high is an address cycle. `wrData[7:0]` is taken as the FIFO index, and no `fifoWr` bit is raised in the following cycle.
- R3: A data write, meaning `pppEn` and `wrEn` high and not an address cycle, made while FIFO k is selected sets only `fifoWr[k]` in the next cycle. In that same cycle, `fifoData` equals the written word.
- R4: The selection persists across any number of data writes and changes only on the next address cycle.
- R5: `fifoByteVal` is 2'b11 (both octets valid) when `oddLast` was 0 with the word, and 2'b10 (only `fifoData[15:8]` valid) when `oddLast` was 1.
- R6: In chunk mode, a data write with `xferStart` high is forwarded as data with `fifoSop`=1. `fifoSop` is 0 for every other forwarded word, and always 0 in addressed mode.
- R7: An address cycle whose index is NUM_FIFOS or greater clears the selection and sets `selErr`. No strobe is raised.
- R8: A data write made while no FIFO is selected raises no strobe and sets `selErr`. `selErr` stays 1 until reset.
- R9: While `pppEn` is 0, writes are ignored. No strobe is raised, and neither the selection nor `selErr` changes.
- R10: At most one `fifoWr` bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pppEn | input | 1 | Enables the interface |
| chunkMode | input | 1 | 1 = chunk mode, 0 = addressed mode |
| wrEn | input | 1 | Write enable for the current word |
| xferStart | input | 1 | Address strobe (addressed mode) or start of packet (chunk mode) |
| oddLast | input | 1 | 1 = only the upper octet of the word is valid |
| wrData | input | 16 | Write data or in-band address |
| fifoWr | output | NUM_FIFOS | One-hot per-FIFO write strobe |
| fifoData | output | 16 | Forwarded word |
| fifoByteVal | output | 2 | Byte-valid marker, bit 1 = upper octet |
| fifoSop | output | 1 | Start-of-packet marker |
| selErr | output | 1 | Sticky addressing error flag |

## Verification
The bench builds the block with the default NUM_FIFOS of 3. With that value, every legal index (0, 1, 2) can be reached, and the indices 3 and 255 exercise the out-of-range path just past the edge and at the top of the address byte. A small FIFO count also lets the bench switch between all destinations many times within a short run, so selection persistence and one-hot strobing can be checked across every destination.

// File: rtl/pktTxPkg.sv
package pktTxPkg;
  localparam int DATA_W = 16;
  localparam logic [1:0] BV_BOTH  = 2'b11;
  localparam logic [1:0] BV_UPPER = 2'b10;

  typedef struct packed {
    logic wrData;
    logic sop;
    logic half;
  } ctrlStrobes_t;
endpackage

// File: rtl/pktTxCtrl.sv
module pktTxCtrl
  import pktTxPkg::*;
#(
  parameter int NUM_FIFOS = 3,
  localparam int SEL_W = (NUM_FIFOS > 1) ? $clog2(NUM_FIFOS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pppEn,
  input  logic             chunkMode,
  input  logic             wrEn,
  input  logic             xferStart,
  input  logic             oddLast,
  input  logic [7:0]       addrByte,
  output ctrlStrobes_t     strobes,
  output logic [SEL_W-1:0] selIdx,
  output logic             selErr
);
  logic isAddr, isData, addrOk, selValid;

  always_comb begin
    isAddr = pppEn & wrEn & ~chunkMode & xferStart;
    isData = pppEn & wrEn & ~isAddr;
    addrOk = ({1'b0, addrByte} < 9'(NUM_FIFOS));
    strobes.wrData = isData & selValid;
    strobes.sop    = isData & selValid & chunkMode & xferStart;
    strobes.half   = oddLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selValid <= 1'b0;
      selIdx   <= '0;
      selErr   <= 1'b0;
    end else begin
      if (isAddr) begin
        selValid <= addrOk;
        if (addrOk) selIdx <= addrByte[SEL_W-1:0];
      end
      if ((isAddr && !addrOk) || (isData && !selValid)) selErr <= 1'b1;
    end
  end
endmodule

// File: rtl/pktTxDatapath.sv
module pktTxDatapath
  import pktTxPkg::*;
#(
  parameter int NUM_FIFOS = 3,
  localparam int SEL_W = (NUM_FIFOS > 1) ? $clog2(NUM_FIFOS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [SEL_W-1:0]     selIdx,
  input  logic [DATA_W-1:0]    wrData,
  output logic [NUM_FIFOS-1:0] fifoWr,
  output logic [DATA_W-1:0]    fifoData,
  output logic [1:0]           fifoByteVal,
  output logic                 fifoSop
);
  logic [NUM_FIFOS-1:0] wrNext;

  for (genvar g = 0; g < NUM_FIFOS; g++) begin : g_dec
    assign wrNext[g] = strobes.wrData && (selIdx == SEL_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fifoWr      <= '0;
      fifoData    <= '0;
      fifoByteVal <= BV_BOTH;
      fifoSop     <= 1'b0;
    end else begin
      fifoWr <= wrNext;
      if (strobes.wrData) begin
        fifoData    <= wrData;
        fifoByteVal <= strobes.half ? BV_UPPER : BV_BOTH;
        fifoSop     <= strobes.sop;
      end else begin
        fifoSop     <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pktTxSteer.sv
module pktTxSteer
  import pktTxPkg::*;
#(
  parameter int NUM_FIFOS = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pppEn,
  input  logic                 chunkMode,
  input  logic                 wrEn,
  input  logic                 xferStart,
  input  logic                 oddLast,
  input  logic [15:0]          wrData,
  output logic [NUM_FIFOS-1:0] fifoWr,
  output logic [15:0]          fifoData,
  output logic [1:0]           fifoByteVal,
  output logic                 fifoSop,
  output logic                 selErr
);
  localparam int SEL_W = (NUM_FIFOS > 1) ? $clog2(NUM_FIFOS) : 1;

  ctrlStrobes_t     strobes;
  logic [SEL_W-1:0] selIdx;

  pktTxCtrl #(.NUM_FIFOS(NUM_FIFOS)) u_ctrl (
    .clk(clk), .rstN(rstN), .pppEn(pppEn), .chunkMode(chunkMode),
    .wrEn(wrEn), .xferStart(xferStart), .oddLast(oddLast),
    .addrByte(wrData[7:0]), .strobes(strobes), .selIdx(selIdx),
    .selErr(selErr)
  );

  pktTxDatapath #(.NUM_FIFOS(NUM_FIFOS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .selIdx(selIdx),
    .wrData(wrData), .fifoWr(fifoWr), .fifoData(fifoData),
    .fifoByteVal(fifoByteVal), .fifoSop(fifoSop)
  );
endmodule

// File: rtl/pktTxSteerChk.sv
module pktTxSteerChk #(
  parameter int NUM_FIFOS = 3
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 pppEn,
  input logic                 chunkMode,
  input logic                 wrEn,
  input logic                 xferStart,
  input logic                 oddLast,
  input logic [NUM_FIFOS-1:0] fifoWr,
  input logic [1:0]           fifoByteVal,
  input logic                 fifoSop,
  input logic                 selErr
);
  assert_onehot_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(fifoWr));

  assert_addr_no_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pppEn && wrEn && !chunkMode && xferStart) |=> (fifoWr == '0));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    selErr |=> selErr);

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !pppEn |=> (fifoWr == '0) && $stable(selErr));

  assert_modulo_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pppEn && wrEn && !(xferStart && !chunkMode)) |=>
      ((fifoWr == '0) || (fifoByteVal == ($past(oddLast) ? 2'b10 : 2'b11))));

  assert_sop_R6: assert property (@(posedge clk) disable iff (!rstN)
    fifoSop |-> ((fifoWr != '0) && $past(chunkMode && xferStart)));
endmodule

bind pktTxSteer pktTxSteerChk #(.NUM_FIFOS(NUM_FIFOS)) u_chk (
  .clk(clk), .rstN(rstN), .pppEn(pppEn), .chunkMode(chunkMode),
  .wrEn(wrEn), .xferStart(xferStart), .oddLast(oddLast),
  .fifoWr(fifoWr), .fifoByteVal(fifoByteVal), .fifoSop(fifoSop),
  .selErr(selErr)
);

// File: tb/pktTxSteer_tb.sv
module pktTxSteer_tb;
  localparam int NF = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pppEn = 1'b0, chunkMode = 1'b0, wrEn = 1'b0, xferStart = 1'b0, oddLast = 1'b0;
  logic [15:0] wrData = '0;
  logic [NF-1:0] fifoWr;
  logic [15:0] fifoData;
  logic [1:0] fifoByteVal;
  logic fifoSop, selErr;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  int mSel = -1;
  bit mErr = 0;
  logic [NF-1:0] eWr = '0;
  logic [15:0] eData = '0;
  logic [1:0] eBv = 2'b11;
  bit eSop = 0;

  always #5 clk = ~clk;

  pktTxSteer #(.NUM_FIFOS(NF)) u_dut (
    .clk(clk), .rstN(rstN), .pppEn(pppEn), .chunkMode(chunkMode),
    .wrEn(wrEn), .xferStart(xferStart), .oddLast(oddLast), .wrData(wrData),
    .fifoWr(fifoWr), .fifoData(fifoData), .fifoByteVal(fifoByteVal),
    .fifoSop(fifoSop), .selErr(selErr)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic modelEdge();
    eWr = '0;
    eSop = 0;
    if (!rstN) begin
      mSel = -1; mErr = 0; eBv = 2'b11; eData = '0;
    end else if (pppEn && wrEn) begin
      if (!chunkMode && xferStart) begin
        if (int'(wrData[7:0]) < NF) mSel = int'(wrData[7:0]);
        else begin mSel = -1; mErr = 1; end
      end else if (mSel >= 0) begin
        eWr[mSel] = 1'b1;
        eData = wrData;
        eBv = oddLast ? 2'b10 : 2'b11;
        eSop = chunkMode && xferStart;
      end else mErr = 1;
    end
  endtask

  task automatic step(string tag, bit en, bit ck, bit we, bit xs, bit od, logic [15:0] d);
    pppEn = en; chunkMode = ck; wrEn = we; xferStart = xs; oddLast = od; wrData = d;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    chk({tag, " strobe"}, 32'(fifoWr), 32'(eWr));
    chk({tag, " err"}, 32'(selErr), 32'(mErr));
    chk({tag, " sop"}, 32'(fifoSop), 32'(eSop));
    if (eWr != '0) begin
      chk({tag, " data"}, 32'(fifoData), 32'(eData));
      chk({tag, " bytes"}, 32'(fifoByteVal), 32'(eBv));
    end
  endtask

  task automatic finishRun();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    @(negedge clk);
    step("R1 reset", 0, 0, 0, 0, 0, 16'h0);
    rstN = 1'b1;
    step("R1 idle", 1, 0, 0, 0, 0, 16'h0);
    // R8: data with nothing selected
    step("R8 no-sel", 1, 0, 1, 0, 0, 16'hAAAA);
    rstN = 1'b0;
    step("R1 re-reset", 0, 0, 0, 0, 0, 16'h0);
    rstN = 1'b1;
    // R2 / R3 / R4 addressed mode
    step("R2 addr1", 1, 0, 1, 1, 0, 16'hFF01);
    step("R3 data f1", 1, 0, 1, 0, 0, 16'h1234);
    step("R4 hold f1", 1, 0, 1, 0, 0, 16'h5678);
    step("R5 odd", 1, 0, 1, 0, 1, 16'h9A00);
    step("R2 addr0", 1, 0, 1, 1, 0, 16'h0000);
    step("R3 data f0", 1, 0, 1, 0, 0, 16'hBEEF);
    step("R2 addr2", 1, 0, 1, 1, 0, 16'h0002);
    step("R10 data f2", 1, 0, 1, 0, 0, 16'hCAFE);
    step("R3 gap", 1, 0, 0, 0, 0, 16'hDEAD);
    step("R4 hold f2", 1, 0, 1, 0, 1, 16'h7700);
    // R9 disabled
    step("R9 off addr", 0, 0, 1, 1, 0, 16'h0000);
    step("R9 off data", 0, 0, 1, 0, 0, 16'h1111);
    step("R9 still f2", 1, 0, 1, 0, 0, 16'h2222);
    // R6 chunk mode
    step("R6 sop", 1, 1, 1, 1, 0, 16'h0001);
    step("R6 mid", 1, 1, 1, 0, 0, 16'h3333);
    step("R6 last odd", 1, 1, 1, 0, 1, 16'h4400);
    step("R6 pkt no sop", 1, 0, 1, 1, 0, 16'h0001);
    step("R6 pkt data", 1, 0, 1, 0, 0, 16'h5555);
    // R7 out of range
    step("R7 addr3", 1, 0, 1, 1, 0, 16'h0003);
    step("R7 dropped", 1, 0, 1, 0, 0, 16'h6666);
    step("R8 sticky", 1, 0, 1, 1, 0, 16'h0000);
    step("R8 sticky data", 1, 0, 1, 0, 0, 16'h7777);
    step("R7 addrFF", 1, 0, 1, 1, 0, 16'h00FF);
    step("R7 chunk dropped", 1, 1, 1, 1, 0, 16'h8888);
    // sweep every FIFO repeatedly
    for (int i = 0; i < 30; i++) begin
      step("R10 sweep addr", 1, 0, 1, 1, 0, 16'(i % NF));
      step("R3 sweep data", 1, i[0], 1, i[1], i[2], 16'(i * 16'h0101 + 3));
    end
    finishRun();
  end
endmodule